// File: doc/BRIEF.md
# Neighborhood Coherence Hazard Scoreboard

This block sits at the entry of a deep event-prediction pipeline. Each candidate event arrives with the 3-D cell coordinate of the particle it involves. The block admits the event only if no event already inside the predictor belongs to the same cell or to any of its 26 surrounding cells. A prediction that would otherwise run on stale neighbor state is held back until the conflicting event has left the predictor.

The space is a 32 x 32 x 32 grid of cells with periodic boundaries. Coordinate 31 and coordinate 0 are neighbors on every axis. The scoreboard is held as a table of in-flight entries, one entry per predictor stage, 23 in all. Each entry holds a valid bit and a cell coordinate. A cell counts as occupied when a valid entry names it.

The upstream logic presents an event for one cycle and receives the outcome one cycle later.
- `admit` means the event was recorded.
- `stall` means it was refused and must be presented again.

A commit input names the cell of an event that has left the predictor, and its entry is retired. A commit in the same cycle as a presentation is already visible to that presentation's check. A flush input empties the whole table when the pipeline restarts.

Top module: `cell_hazard_gate`

## Requirements
- R1: After reset, `admit` and `stall` are low and no cell is in flight, so any first event is admitted.
- R2: An event presented with `req_valid` high is admitted when two conditions hold: fewer than 23 events are in flight, and none of the in-flight events lies in its neighborhood. The neighborhood is every cell whose x, y and z each differ from the event's by -1, 0 or +1, modulo 32. `admit` is then high for exactly the next cycle, and the event's cell is in flight from then on.
- R3: An event whose neighborhood holds an in-flight event, including the case of its own cell, is refused. `stall` is high in the next cycle and nothing is recorded.
- R4: Neighborhoods wrap around. Coordinate values 31 and 0 are adjacent on each axis.
- R5: A commit (`cmt_valid` high with `cmt_x/y/z`) retires one in-flight event in that cell. Later events near that cell are no longer refused because of it.
- R6: A commit takes effect for an event presented in the same cycle. It clears that event's hazard, and it frees capacity for it when all 23 entries are in use.
- R7: A commit naming a cell with no in-flight event changes nothing.
- R8: `flush` empties the table. An event presented in the flush cycle is refused with `stall` and is not recorded.
- R9: With 23 events in flight and no commit, a further event is refused even when its neighborhood is free.
- R10: When `req_valid` is low, both outputs are low in the next cycle. `admit` and `stall` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Empties the in-flight table |
| cmt_valid | input | 1 | A committing event's cell is on cmt_x/y/z |
| cmt_x | input | 5 | Committing cell, x |
| cmt_y | input | 5 | Committing cell, y |
| cmt_z | input | 5 | Committing cell, z |
| req_valid | input | 1 | An event asks for entry |
| req_x | input | 5 | Entering cell, x |
| req_y | input | 5 | Entering cell, y |
| req_z | input | 5 | Entering cell, z |
| admit | output | 1 | Event of the previous cycle was recorded |
| stall | output | 1 | Event of the previous cycle was refused |

## Verification
A corrupted table entry surfaces at the ports on the first later event that lands near either the stale cell or the lost one. It appears as a `stall` where `admit` was due, or the reverse, one cycle after that presentation. A lost commit bypass shows in the same-cycle commit vectors. A wrong wrap shows on events placed across the 31/0 seam. A miscounted capacity shows when the table is filled to exactly 23 entries and then given one more event, with and without a simultaneous commit.

// File: rtl/chg_pkg.sv
package chg_pkg;

  // Bits per axis; the grid is 2**AXIS_W cells on each side.
  localparam int unsigned AXIS_W = 5;
  localparam int unsigned GRID   = 1 << AXIS_W;

  typedef struct packed {
    logic [AXIS_W-1:0] x;
    logic [AXIS_W-1:0] y;
    logic [AXIS_W-1:0] z;
  } cell_t;

  // Two coordinates are adjacent when their modular difference is -1, 0 or +1.
  function automatic logic axis_adjacent(input logic [AXIS_W-1:0] a,
                                         input logic [AXIS_W-1:0] b);
    logic [AXIS_W-1:0] d;
    d = a - b;
    return (d == '0) || (d == AXIS_W'(1)) || (d == '1);
  endfunction

  function automatic logic cell_adjacent(input cell_t a, input cell_t b);
    return axis_adjacent(a.x, b.x) && axis_adjacent(a.y, b.y) &&
           axis_adjacent(a.z, b.z);
  endfunction

endpackage

// File: rtl/chg_rst_sync.sv
module chg_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/chg_slot_table.sv
module chg_slot_table
  import chg_pkg::*;
#(
  parameter int unsigned DEPTH = 23
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 wr_en_i,
  input  cell_t                wr_cell_i,
  input  logic                 clr_en_i,
  input  cell_t                clr_cell_i,
  output logic [DEPTH-1:0]     live_o,
  output cell_t [DEPTH-1:0]    cells_o,
  output logic                 full_o
);

  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  valid_d;
  logic              valid_en;
  logic [DEPTH-1:0]  match_vec;
  logic [DEPTH-1:0]  clr_vec;
  logic [DEPTH-1:0]  live;
  logic [DEPTH-1:0]  free_vec;
  logic [DEPTH-1:0]  wr_sel;
  cell_t [DEPTH-1:0] cell_q;

  // Commit lookup: which valid entries hold the committing cell.
  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign match_vec[i] = clr_en_i && valid_q[i] && (cell_q[i] == clr_cell_i);
  end

  // Next-state logic.
  always_comb begin
    // Retire only the lowest matching entry, so that one commit frees one event.
    clr_vec  = match_vec & (~match_vec + DEPTH'(1));
    live     = valid_q & ~clr_vec;
    free_vec = ~live;
    wr_sel   = free_vec & (~free_vec + DEPTH'(1));
    valid_en = flush_i | wr_en_i | clr_en_i;
    if (flush_i) begin
      valid_d = '0;
    end else begin
      valid_d = live | (wr_en_i ? wr_sel : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (valid_en) begin
      valid_q <= valid_d;
    end
  end

  // Coordinate payload: written only into the selected free entry.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en_i && wr_sel[i]) begin
        cell_q[i] <= wr_cell_i;
      end
    end
  end

  assign live_o  = live;
  assign cells_o = cell_q;
  assign full_o  = &live;

  // R2: an admission with no commit and no flush adds exactly one entry.
  a_r2_admit_grows: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_i && !flush_i && !clr_en_i) |=>
      ($countones(valid_q) == $countones($past(valid_q)) + 1));

  // R8: a flush leaves no entry valid.
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));

  // R9: the gate never writes when every entry is still live.
  a_r9_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en_i |-> (|free_vec));

endmodule

// File: rtl/chg_neigh_match.sv
module chg_neigh_match
  import chg_pkg::*;
#(
  parameter int unsigned DEPTH = 23
) (
  input  logic [DEPTH-1:0]  live_i,
  input  cell_t [DEPTH-1:0] cells_i,
  input  cell_t             probe_i,
  output logic              hit_o
);

  logic [DEPTH-1:0] near_vec;

  // One wrap-around 27-cell compare per in-flight entry.
  for (genvar i = 0; i < DEPTH; i++) begin : g_near
    assign near_vec[i] = live_i[i] && cell_adjacent(cells_i[i], probe_i);
  end

  assign hit_o = |near_vec;

endmodule

// File: rtl/cell_hazard_gate.sv
module cell_hazard_gate
  import chg_pkg::*;
#(
  parameter int unsigned DEPTH = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              cmt_valid,
  input  logic [AXIS_W-1:0] cmt_x,
  input  logic [AXIS_W-1:0] cmt_y,
  input  logic [AXIS_W-1:0] cmt_z,
  input  logic              req_valid,
  input  logic [AXIS_W-1:0] req_x,
  input  logic [AXIS_W-1:0] req_y,
  input  logic [AXIS_W-1:0] req_z,
  output logic              admit,
  output logic              stall
);

  logic              rst_s_n;
  cell_t             req_cell;
  cell_t             cmt_cell;
  logic [DEPTH-1:0]  live;
  cell_t [DEPTH-1:0] cells;
  logic              full;
  logic              hit;
  logic              take;
  logic              admit_d;
  logic              stall_d;
  logic              admit_q;
  logic              stall_q;

  chg_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_s_n)
  );

  assign req_cell = '{x: req_x, y: req_y, z: req_z};
  assign cmt_cell = '{x: cmt_x, y: cmt_y, z: cmt_z};

  chg_slot_table #(.DEPTH(DEPTH)) u_table (
    .clk        (clk),
    .rst_ni     (rst_s_n),
    .flush_i    (flush),
    .wr_en_i    (take),
    .wr_cell_i  (req_cell),
    .clr_en_i   (cmt_valid),
    .clr_cell_i (cmt_cell),
    .live_o     (live),
    .cells_o    (cells),
    .full_o     (full)
  );

  // The table's live vector already excludes a same-cycle commit, so the
  // check sees it at once.
  chg_neigh_match #(.DEPTH(DEPTH)) u_match (
    .live_i  (live),
    .cells_i (cells),
    .probe_i (req_cell),
    .hit_o   (hit)
  );

  // Next-state logic.
  always_comb begin
    take    = req_valid && !flush && !hit && !full;
    admit_d = take;
    stall_d = req_valid && !take;
  end

  // Registered outcome.
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      admit_q <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      admit_q <= admit_d;
      stall_q <= stall_d;
    end
  end

  assign admit = admit_q;
  assign stall = stall_q;

  // R10: the two outcomes never appear together.
  a_r10_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(admit_q && stall_q));

  // R10: no request, no outcome.
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    !req_valid |=> (!admit_q && !stall_q));

  // R8: an event presented during a flush is refused.
  a_r8_flush_refuses: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && flush) |=> stall_q);

endmodule

// File: tb/cell_hazard_gate_bench.sv
module cell_hazard_gate_bench;

  typedef struct packed {
    logic       fl;
    logic       cv;
    logic [4:0] cx;
    logic [4:0] cy;
    logic [4:0] cz;
    logic       rv;
    logic [4:0] rx;
    logic [4:0] ry;
    logic [4:0] rz;
    logic       ea;
    logic       es;
    logic [7:0] tag;
  } vec_t;

  localparam int NV = 19;
  // Fields: flush, commit valid, commit x y z, request valid, request x y z,
  // expected admit, expected stall, requirement number.
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd5,5'd5,5'd5,     1'b1,1'b0,8'd2},  // R2 first
    '{1'b0,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd5,5'd5,5'd5,     1'b0,1'b1,8'd3},  // R3 same cell
    '{1'b0,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd6,5'd6,5'd6,     1'b0,1'b1,8'd3},  // R3 corner
    '{1'b0,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd4,5'd5,5'd6,     1'b0,1'b1,8'd3},  // R3 edge
    '{1'b0,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd7,5'd5,5'd5,     1'b1,1'b0,8'd2},  // R2 dx=2
    '{1'b0,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd0,5'd10,5'd10,   1'b1,1'b0,8'd2},  // R2
    '{1'b0,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd31,5'd10,5'd11,  1'b0,1'b1,8'd4},  // R4 wrap x
    '{1'b0,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd30,5'd10,5'd10,  1'b1,1'b0,8'd4},  // R4 distance 2 across seam
    '{1'b0,1'b1,5'd5,5'd5,5'd5,    1'b1,5'd5,5'd5,5'd4,     1'b1,1'b0,8'd6},  // R6 bypass
    '{1'b0,1'b1,5'd7,5'd5,5'd5,    1'b0,5'd0,5'd0,5'd0,     1'b0,1'b0,8'd10}, // R10 idle + commit
    '{1'b0,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd8,5'd5,5'd5,     1'b1,1'b0,8'd5},  // R5 freed
    '{1'b0,1'b1,5'd20,5'd20,5'd20, 1'b0,5'd0,5'd0,5'd0,     1'b0,1'b0,8'd7},  // R7 stray commit
    '{1'b0,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd5,5'd5,5'd5,     1'b0,1'b1,8'd7},  // R7 554 still live
    '{1'b1,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd9,5'd9,5'd9,     1'b0,1'b1,8'd8},  // R8 flush refuses
    '{1'b0,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd5,5'd5,5'd5,     1'b1,1'b0,8'd8},  // R8 table empty
    '{1'b0,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd31,5'd10,5'd10,  1'b1,1'b0,8'd8},  // R8
    '{1'b0,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd0,5'd11,5'd11,   1'b0,1'b1,8'd4},  // R4 wrap 0 vs 31
    '{1'b0,1'b1,5'd31,5'd10,5'd10, 1'b1,5'd0,5'd11,5'd11,   1'b1,1'b0,8'd6},  // R6
    '{1'b0,1'b0,5'd0,5'd0,5'd0,    1'b1,5'd4,5'd4,5'd4,     1'b0,1'b1,8'd3}   // R3 corner of 555
  };

  logic       clk;
  logic       rst_n;
  logic       flush;
  logic       cmt_valid;
  logic [4:0] cmt_x, cmt_y, cmt_z;
  logic       req_valid;
  logic [4:0] req_x, req_y, req_z;
  logic       admit;
  logic       stall;

  int checks;
  int fails;
  bit done;

  cell_hazard_gate u_cell_hazard_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .cmt_valid (cmt_valid),
    .cmt_x     (cmt_x),
    .cmt_y     (cmt_y),
    .cmt_z     (cmt_z),
    .req_valid (req_valid),
    .req_x     (req_x),
    .req_y     (req_y),
    .req_z     (req_z),
    .admit     (admit),
    .stall     (stall)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic ea, input logic es);
    checks++;
    if (admit !== ea || stall !== es) begin
      fails++;
      $display("FAIL %s: admit/stall = %b/%b, expected %b/%b", req, admit, stall, ea, es);
    end
  endtask

  task automatic drive(input logic fl, input logic cv, input logic [4:0] cx,
                       input logic [4:0] cy, input logic [4:0] cz, input logic rv,
                       input logic [4:0] rx, input logic [4:0] ry, input logic [4:0] rz);
    flush = fl; cmt_valid = cv; cmt_x = cx; cmt_y = cy; cmt_z = cz;
    req_valid = rv; req_x = rx; req_y = ry; req_z = rz;
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check.
  task automatic step(input string req, input logic fl, input logic cv,
                      input logic [4:0] cx, input logic [4:0] cy, input logic [4:0] cz,
                      input logic rv, input logic [4:0] rx, input logic [4:0] ry,
                      input logic [4:0] rz, input logic ea, input logic es);
    drive(fl, cv, cx, cy, cz, rv, rx, ry, rz);
    @(negedge clk);
    chk(req, ea, es);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 5'd0, 5'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    @(negedge clk);
    do_reset();
    chk("R1 reset outputs", 1'b0, 1'b0);

    // Table walk.
    for (int k = 0; k < NV; k++) begin
      step($sformatf("R%0d vector %0d", TBL[k].tag, k), TBL[k].fl, TBL[k].cv,
           TBL[k].cx, TBL[k].cy, TBL[k].cz, TBL[k].rv, TBL[k].rx, TBL[k].ry,
           TBL[k].rz, TBL[k].ea, TBL[k].es);
    end

    // R9: fill to capacity with cells 3 apart.
    step("R8 flush idle", 1'b1, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0);
    for (int i = 0; i < 23; i++) begin
      step("R9 fill", 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1,
           5'(3 * (i % 10)), 5'(3 * (i / 10)), 5'd20, 1'b1, 1'b0);
    end
    step("R9 full refuses", 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd15, 5'd15, 5'd15, 1'b0, 1'b1);
    step("R6 commit frees slot", 1'b0, 1'b1, 5'd0, 5'd0, 5'd20, 1'b1, 5'd15, 5'd15, 5'd15, 1'b1, 1'b0);
    step("R9 full again", 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd20, 5'd20, 5'd5, 1'b0, 1'b1);
    step("R5 commit idle", 1'b0, 1'b1, 5'd3, 5'd0, 5'd20, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0);
    step("R5 after commit", 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd20, 5'd20, 5'd5, 1'b1, 1'b0);

    // R1: reset mid-run clears every in-flight cell.
    do_reset();
    chk("R1 outputs after reset", 1'b0, 1'b0);
    step("R1 table cleared", 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd6, 5'd0, 5'd20, 1'b1, 1'b0);
    step("R10 idle", 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd6, 5'd0, 5'd20, 1'b0, 1'b0);

    done = 1'b1;
    finish_run();
  end

endmodule